// File: doc/BRIEF.md
# Byte-Programmed PWM Generator with Auto-Off Timer

This block produces one pulse-width-modulated output, configured by a host through a narrow write-only port that carries one 8-bit address and one 8-bit data byte per cycle. The period and the high time are 16-bit counts of a fixed time base. This tick is derived from the system clock by a prescaler. The output is high at the start of every period and drops once the high-time count has elapsed.

Each 16-bit value is loaded in two byte writes. The upper byte is held in a staging register and has no effect on its own. The full value becomes live in the same edge that writes its lower byte. Period and high time are therefore committed independently of each other. An optional countdown, measured in completed PWM periods, switches the generator off when it expires. It is armed with any value except zero and all-ones, and either of those two values disarms it.

Top module: `regpwm`

## Requirements
- R1: After reset the output is low, the generator is disabled, both live values are 0 and the countdown is disarmed.
- R2: A write to an upper-byte address (0xA5 period, 0xA7 high time, 0xA1 countdown) only stages the byte. The 16-bit value {staged byte, data} goes live on the edge that writes the matching lower-byte address (0xA4 period, 0xA6 high time, 0xA2 countdown).
- R3: While enabled, the count advances once every TICK_DIV clocks and returns to 0 after reaching period−1, so one PWM period lasts period×TICK_DIV clocks. The count starts at 0 with a fresh prescaler phase on the edge that enables the generator.
- R4: While enabled with a nonzero period, the output is high while the count is below the high-time value, which gives min(duty, period)×TICK_DIV high clocks per period starting at the beginning of the period.
- R5: A high-time value greater than or equal to the period keeps the output high for the whole period.
- R6: A high-time value of 0 keeps the output low. Committing a nonzero value afterwards resumes normal pulses without any write to the enable address.
- R7: A period of 0 keeps the output low.
- R8: Bit 0 of a write to address 0xA3 sets (1) or clears (0) the enable. The other bits are ignored. When the enable is clear, the output is low from the cycle after the write.
- R9: Committing a countdown value N other than 0 and 0xFFFF clears the enable at the end of the N-th complete PWM period counted from the first wrap after arming. The countdown then disarms itself, so re-enabling gives continuous output. A value of 0 also disarms it.
- R10: Committing 0xFFFF disarms the countdown, including one that is already running, and the output then runs indefinitely.
- R11: A write to any address outside 0xA1 to 0xA7 has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Data byte of the write |
| pwm_out | output | 1 | PWM output, normal polarity |

## Verification
The generator is tried with a table of period/high-time pairs. The pairs include a high time below the period, a high time equal to the period, a high time above it, a high time of zero, a period of zero, a period of one and a period that needs both bytes. High clocks are counted over windows of whole periods, which separates a correct comparator from off-by-one count limits and a wrong wrap point. Directed sequences stage an upper byte without its lower byte to show that no value goes live early. They also pause and resume through the enable bit, write to unmapped addresses, and run the countdown with an armed value, with zero, with all-ones and with a cancellation mid-run. Counting the high clocks in each case tells an expiry that arrives a period early or late apart from a countdown that never arms.

// File: rtl/regpwm_pkg.sv
package regpwm_pkg;

    localparam int BYTE_W = 8;
    localparam int VAL_W  = 2 * BYTE_W;

    // Address map: the host software depends on these offsets
    localparam logic [BYTE_W-1:0] ADR_AOFF_HI = 8'hA1;
    localparam logic [BYTE_W-1:0] ADR_AOFF_LO = 8'hA2;
    localparam logic [BYTE_W-1:0] ADR_ENABLE  = 8'hA3;
    localparam logic [BYTE_W-1:0] ADR_PER_LO  = 8'hA4;
    localparam logic [BYTE_W-1:0] ADR_PER_HI  = 8'hA5;
    localparam logic [BYTE_W-1:0] ADR_DUTY_LO = 8'hA6;
    localparam logic [BYTE_W-1:0] ADR_DUTY_HI = 8'hA7;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [VAL_W-1:0]  val_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_AOFF_HI,
        SEL_AOFF_LO,
        SEL_EN,
        SEL_PER_LO,
        SEL_PER_HI,
        SEL_DUTY_LO,
        SEL_DUTY_HI
    } sel_e;

    function automatic sel_e decode_addr(input byte_t a);
        sel_e s;
        case (a)
            ADR_AOFF_HI: s = SEL_AOFF_HI;
            ADR_AOFF_LO: s = SEL_AOFF_LO;
            ADR_ENABLE:  s = SEL_EN;
            ADR_PER_LO:  s = SEL_PER_LO;
            ADR_PER_HI:  s = SEL_PER_HI;
            ADR_DUTY_LO: s = SEL_DUTY_LO;
            ADR_DUTY_HI: s = SEL_DUTY_HI;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/regpwm_prescale.sv
module regpwm_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] phase;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.phase = '0;
        end else if (st_q.phase == LAST) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = run_i && (st_q.phase == LAST);

    generate
        if (DIV > 1) begin : g_gap_chk
            // R3: ticks are never back to back when the divider exceeds one
            a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/regpwm_regfile.sv
module regpwm_regfile
    import regpwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en_i,
    input  byte_t wr_addr_i,
    input  byte_t wr_data_i,
    input  logic  expire_i,
    output logic  en_o,
    output val_t  per_o,
    output val_t  duty_o,
    output logic  aoff_load_o,
    output val_t  aoff_val_o
);
    typedef struct packed {
        logic  en;
        byte_t per_stage;
        byte_t duty_stage;
        byte_t aoff_stage;
        val_t  per;
        val_t  duty;
    } rf_st_t;

    rf_st_t st_d, st_q;
    sel_e   sel;

    always_comb begin
        st_d        = st_q;
        sel         = wr_en_i ? decode_addr(wr_addr_i) : SEL_NONE;
        aoff_load_o = 1'b0;
        aoff_val_o  = {st_q.aoff_stage, wr_data_i};

        // countdown expiry first, so a host enable write on the same edge wins
        if (expire_i) st_d.en = 1'b0;

        case (sel)
            SEL_EN:      st_d.en         = wr_data_i[0];
            SEL_PER_HI:  st_d.per_stage  = wr_data_i;
            SEL_PER_LO:  st_d.per        = {st_q.per_stage, wr_data_i};
            SEL_DUTY_HI: st_d.duty_stage = wr_data_i;
            SEL_DUTY_LO: st_d.duty       = {st_q.duty_stage, wr_data_i};
            SEL_AOFF_HI: st_d.aoff_stage = wr_data_i;
            SEL_AOFF_LO: aoff_load_o     = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign per_o  = st_q.per;
    assign duty_o = st_q.duty;

    // R2: an upper-byte write alone leaves the live period untouched
    a_r2_per_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADR_PER_HI) |=> $stable(per_o));

    // R2: an upper-byte write alone leaves the live high time untouched
    a_r2_duty_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADR_DUTY_HI) |=> $stable(duty_o));

    // R9: expiry clears the enable unless the host rewrites it on that edge
    a_r9_expire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !(wr_en_i && wr_addr_i == ADR_ENABLE)) |=> !en_o);

endmodule

// File: rtl/regpwm_wave.sv
module regpwm_wave
    import regpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  val_t per_i,
    input  val_t duty_i,
    output logic pwm_o,
    output logic wrap_o
);
    typedef struct packed {
        val_t cnt;
    } wv_st_t;

    wv_st_t st_d, st_q;
    logic   active;
    logic   at_end;

    always_comb begin
        active = en_i && (per_i != '0);
        at_end = st_q.cnt >= (per_i - 1'b1);
        wrap_o = active && tick_i && at_end;

        st_d = st_q;
        if (!active) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = active && (st_q.cnt < duty_i);

    // R3: without a tick the count only moves if the generator stops
    a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick_i) |=> (!(en_i && per_i != '0) || $stable(st_q.cnt)));

    // R4: every period opens with the output high when the high time is nonzero
    a_r4_high_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && per_i != '0 && duty_i != '0 && st_q.cnt == '0) |-> pwm_o);

    // R7: a zero period never drives the output high
    a_r7_zero_period_low: assert property (@(posedge clk) disable iff (!rst_n)
        (per_i == '0) |-> !pwm_o);

endmodule

// File: rtl/regpwm_autooff.sv
module regpwm_autooff
    import regpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  val_t val_i,
    input  logic wrap_i,
    output logic expire_o
);
    localparam val_t OFF_CODE = '1;

    typedef struct packed {
        logic armed;
        val_t remain;
    } ao_st_t;

    ao_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_i) begin
            if (val_i == '0 || val_i == OFF_CODE) begin
                st_d.armed  = 1'b0;
                st_d.remain = '0;
            end else begin
                st_d.armed  = 1'b1;
                st_d.remain = val_i;
            end
        end else if (st_q.armed && wrap_i) begin
            if (st_q.remain == val_t'(1)) begin
                st_d.armed  = 1'b0;
                st_d.remain = '0;
                expire_o    = 1'b1;
            end else begin
                st_d.remain = st_q.remain - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: the countdown only moves at a period wrap or a new commit
    a_r9_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !wrap_i && !load_i) |=> $stable(st_q.remain));

    // R9: expiry coincides with a period wrap
    a_r9_expire_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> wrap_i);

    // R10: committing the all-ones code leaves the timer disarmed
    a_r10_ones_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && val_i == OFF_CODE) |=> !st_q.armed);

endmodule

// File: rtl/regpwm.sv
module regpwm
    import regpwm_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       pwm_out
);
    logic en;
    val_t per;
    val_t duty;
    logic aoff_load;
    val_t aoff_val;
    logic expire;
    logic tick;
    logic wrap;

    regpwm_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .expire_i    (expire),
        .en_o        (en),
        .per_o       (per),
        .duty_o      (duty),
        .aoff_load_o (aoff_load),
        .aoff_val_o  (aoff_val)
    );

    regpwm_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (en),
        .tick_o (tick)
    );

    regpwm_wave u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .tick_i (tick),
        .per_i  (per),
        .duty_i (duty),
        .pwm_o  (pwm_out),
        .wrap_o (wrap)
    );

    regpwm_autooff u_aoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (aoff_load),
        .val_i    (aoff_val),
        .wrap_i   (wrap),
        .expire_o (expire)
    );

    // R8: a cleared enable holds the output low
    a_r8_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm_out);

endmodule

// File: tb/regpwm_tb_top.sv
module regpwm_tb_top;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    regpwm #(.TICK_DIV(DIV)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    // period, high time, expected high ticks per period
    localparam int NV = 10;
    localparam int VEC [NV][3] = '{
        '{10,   3,   3},   // R4
        '{10,   0,   0},   // R6
        '{10,  10,  10},   // R5
        '{6,    9,   6},   // R5
        '{0,    5,   0},   // R7
        '{1,    1,   1},   // R5
        '{1,    0,   0},   // R6
        '{20,   1,   1},   // R4
        '{300, 150, 150},  // R2 both bytes
        '{7,    6,   6}    // R4
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_addr = 8'h00;
        wr_data = 8'h00;
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            hi += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    task automatic setup(input int p, input int d);
        wr(8'hA3, 8'h00);
        wr(8'hA5, 8'(p >> 8));
        wr(8'hA4, 8'(p));
        wr(8'hA7, 8'(d >> 8));
        wr(8'hA6, 8'(d));
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi;
        repeat (5) @(negedge clk);
        chk("R1 output low in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        count_high(20, hi);
        chk("R1 output low after reset", hi, 0);

        // R7: default period is zero, enabling alone gives nothing
        wr(8'hA3, 8'h01);
        count_high(40, hi);
        chk("R7 reset period zero stays low", hi, 0);
        wr(8'hA3, 8'h00);

        // table walk: two full periods per vector
        for (int v = 0; v < NV; v++) begin
            int p, win;
            p = VEC[v][0];
            setup(p, VEC[v][1]);
            wr(8'hA3, 8'h01);
            win = (p == 0) ? 40 : 2 * p * DIV;
            count_high(win, hi);
            chk($sformatf("R4 vector %0d p=%0d d=%0d", v, p, VEC[v][1]),
                hi, 2 * VEC[v][2] * DIV);
        end

        // R3: exact edge placement with period 10, high time 3
        setup(10, 3);
        wr(8'hA3, 8'h01);
        count_high(12, hi);
        chk("R3 first high run length", hi, 12);
        chk("R3 falls after high time", int'(pwm_out), 0);
        count_high(28, hi);
        chk("R3 low for rest of period", hi, 0);
        chk("R3 next period starts high", int'(pwm_out), 1);
        count_high(40, hi);
        chk("R3 second period high count", hi, 12);

        // R2: upper byte staged only
        wr(8'hA7, 8'h01);
        count_high(80, hi);
        chk("R2 staged upper byte has no effect", hi, 24);
        wr(8'hA6, 8'h00);
        count_high(80, hi);
        chk("R2 R5 commit gives 0x0100 full high", hi, 80);

        // R6: zero high time then resume without enable writes
        wr(8'hA7, 8'h00);
        wr(8'hA6, 8'h00);
        count_high(80, hi);
        chk("R6 zero high time low", hi, 0);
        wr(8'hA6, 8'h04);
        count_high(80, hi);
        chk("R6 resumes without enable toggle", hi, 32);

        // R11: unmapped addresses
        wr(8'hA0, 8'hFF);
        wr(8'hA8, 8'h00);
        wr(8'h00, 8'h00);
        count_high(80, hi);
        chk("R11 unmapped writes ignored", hi, 32);

        // R8: enable bit 0 semantics
        wr(8'hA3, 8'h00);
        chk("R8 low right after disable", int'(pwm_out), 0);
        count_high(40, hi);
        chk("R8 stays low while disabled", hi, 0);
        wr(8'hA3, 8'h02);
        count_high(40, hi);
        chk("R8 bit1 alone does not enable", hi, 0);
        wr(8'hA3, 8'h03);
        count_high(80, hi);
        chk("R8 bit0 enables", hi, 32);

        // R9: countdown of 3 periods, period 4, high time 2
        setup(4, 2);
        wr(8'hA1, 8'h00);
        wr(8'hA2, 8'h03);
        wr(8'hA3, 8'h01);
        count_high(160, hi);
        chk("R9 three periods then off", hi, 24);
        chk("R9 output low after expiry", int'(pwm_out), 0);
        wr(8'hA3, 8'h01);
        count_high(64, hi);
        chk("R9 disarmed after expiry", hi, 32);

        // R9: value zero disarms
        wr(8'hA3, 8'h00);
        wr(8'hA1, 8'h00);
        wr(8'hA2, 8'h00);
        wr(8'hA3, 8'h01);
        count_high(160, hi);
        chk("R9 zero value never expires", hi, 80);

        // R10: all-ones disarms
        wr(8'hA3, 8'h00);
        wr(8'hA1, 8'hFF);
        wr(8'hA2, 8'hFF);
        wr(8'hA3, 8'h01);
        count_high(160, hi);
        chk("R10 all ones runs on", hi, 80);

        // R10: cancel a running countdown
        wr(8'hA3, 8'h00);
        wr(8'hA1, 8'h00);
        wr(8'hA2, 8'h02);
        wr(8'hA3, 8'h01);
        wr(8'hA1, 8'hFF);
        wr(8'hA2, 8'hFF);
        count_high(160, hi);
        chk("R10 cancel running countdown", hi, 80);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule